// File: doc/BRIEF.md
# Serial Configuration Load Sequencer

This block handles the receiving end of a passive serial configuration load and the start-up phase that follows it. When the status line is released high, the sequencer enables the upstream bit source. It then takes one bit from the serial data input on each rising edge of an external configuration clock. Bits are packed into words and counted against a fixed image length. When the last bit arrives, the configuration-done flag rises. That flag also drives the active-low chip select of the upstream source, so the rise stops the stream and any later configuration clock edges are ignored.

After configuration-done, the flag crosses into the initialization clock domain through a two-stage synchronizer. A fixed countdown then runs on that clock. The clock is the internal oscillator by default, or the user clock when the selection input is set. If the user clock is selected and stays still, start-up waits for as long as it stays still. When the countdown ends, init-done rises and the block enters user mode. If the status line drops at any point, the sequencer returns to idle and clears all progress.

All external clocks and the status and data lines are treated as asynchronous levels. They are synchronized to the system clock `clk`, and their rising edges are detected there.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset, `bit_count`, `cfg_done`, `init_done`, `user_mode`, `src_oe`, `word_valid` and `word_out` are all zero.
- R2: While `stat_rel` is low, `cfg_clk` edges are ignored (`bit_count` stays 0). Once `stat_rel` is high and loading is under way, `src_oe` is 1.
- R3: Each rising edge of `cfg_clk` during loading takes the level of `cfg_data` and increments `bit_count` by one.
- R4: `cfg_done` rises when `bit_count` reaches `IMAGE_BITS` (default 64) and not earlier.
- R5: Once `cfg_done` is high, `src_oe` is 0 and further `cfg_clk` edges leave `bit_count` unchanged. `bit_count` never exceeds `IMAGE_BITS`.
- R6: After every `WORD_W` (default 8) received bits, `word_out` takes the packed group and `word_valid` pulses. The first bit received in a group lands in bit 0 and the last lands in bit `WORD_W-1`.
- R7: `init_done` rises on the 301st rising edge of the selected initialization clock after `cfg_done` rises (2 synchronizer edges plus `INIT_CYCLES` = 299 counted edges). It is still low after the 300th edge.
- R8: With `usr_clk_sel` = 0 the initialization clock is `osc_clk`; with `usr_clk_sel` = 1 it is `usr_clk`. Edges of the clock that is not selected do not advance start-up. `init_done` stays low for as long as the selected clock does not toggle.
- R9: `usr_clk` edges during loading do not change `bit_count` or `cfg_done`.
- R10: If `stat_rel` goes low during loading, initialization or user mode, `bit_count`, `cfg_done` and `init_done` return to 0.
- R11: `user_mode` always equals `init_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| rst | input | 1 | Synchronous active-high reset |
| stat_rel | input | 1 | Status release; high allows loading, low aborts to idle |
| cfg_clk | input | 1 | Configuration clock; a rising edge takes one data bit |
| cfg_data | input | 1 | Serial configuration data |
| osc_clk | input | 1 | Internal oscillator, default initialization clock |
| usr_clk | input | 1 | User-supplied initialization clock |
| usr_clk_sel | input | 1 | 1 selects usr_clk for initialization |
| src_oe | output | 1 | Output enable for the upstream source, high while loading |
| cfg_done | output | 1 | Image fully received; also the active-low select of the source |
| init_done | output | 1 | Initialization finished |
| user_mode | output | 1 | Block is in user mode |
| bit_count | output | 7 | Bits accepted so far |
| word_out | output | 8 | Last completed packed word |
| word_valid | output | 1 | One-cycle pulse when word_out updates |

## Verification
The hardest case to reach is the exact end of the initialization countdown. It lies more than three hundred selected-clock edges after `cfg_done`, and it depends on which clock is selected. The stimulus pulses the selected clock exactly 300 times and checks that `init_done` is still low. It then gives one more edge and checks that `init_done` has risen. Before that, it pulses the unselected clock heavily and checks that nothing moves. A separate run aborts after start-up has begun, to confirm that a half-finished countdown does not carry over into the next load.

// File: rtl/cfg_load_seq_pkg.sv
package cfg_load_seq_pkg;

    localparam int DEF_IMAGE_BITS  = 64;
    localparam int DEF_WORD_W      = 8;
    localparam int DEF_INIT_CYCLES = 299;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_INIT = 2'd2,
        SEQ_USER = 2'd3
    } seq_state_e;

    // synchronized view of the asynchronous inputs
    typedef struct packed {
        logic stat;
        logic cfg_clk;
        logic cfg_data;
        logic osc;
        logic usr;
    } in_lvls_t;

    localparam int IN_LVLS_W = $bits(in_lvls_t);

    function automatic logic rising(input logic prev, input logic cur);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfg_bit_loader.sv
module cfg_bit_loader #(
    parameter int IMAGE_BITS = 64,
    parameter int WORD_W     = 8,
    localparam int CNT_W     = $clog2(IMAGE_BITS + 1),
    localparam int POS_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              en,
    input  logic              tick,
    input  logic              din,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic [WORD_W-1:0] word,
    output logic              word_stb
);
    logic [WORD_W-1:0] shreg;
    logic [POS_W-1:0]  pos;
    logic              take;
    logic              last_of_word;
    logic [WORD_W-1:0] shnext;

    assign full         = (count == CNT_W'(IMAGE_BITS));
    assign take         = en & tick & ~full;
    assign last_of_word = (pos == POS_W'(WORD_W - 1));
    assign shnext       = {din, shreg[WORD_W-1:1]};

    always_ff @(posedge clk) begin
        if (clr) begin
            count    <= '0;
            shreg    <= '0;
            pos      <= '0;
            word     <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            if (take) begin
                count <= count + 1'b1;
                shreg <= shnext;
                if (last_of_word) begin
                    pos      <= '0;
                    word     <= shnext;
                    word_stb <= 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_init_timer.sv
module cfg_init_timer #(
    parameter int INIT_CYCLES = 299,
    parameter int SYNC_STAGES = 2,
    localparam int IC_W       = $clog2(INIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    input  logic done_in,
    output logic fin
);
    logic [SYNC_STAGES-1:0] dsync;
    logic [IC_W-1:0]        icnt;

    // synchronizer advances only on edges of the init clock
    always_ff @(posedge clk) begin
        if (clr)       dsync <= '0;
        else if (tick) dsync <= {dsync[SYNC_STAGES-2:0], done_in};
    end

    // counter is cleared in the init domain until the synced flag arrives
    always_ff @(posedge clk) begin
        if (clr) begin
            icnt <= '0;
        end else if (tick) begin
            if (!dsync[SYNC_STAGES-1])                icnt <= '0;
            else if (icnt != IC_W'(INIT_CYCLES))      icnt <= icnt + 1'b1;
        end
    end

    assign fin = dsync[SYNC_STAGES-1] & (icnt == IC_W'(INIT_CYCLES));
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_load_seq_pkg::*;
#(
    parameter int IMAGE_BITS  = DEF_IMAGE_BITS,
    parameter int WORD_W      = DEF_WORD_W,
    parameter int INIT_CYCLES = DEF_INIT_CYCLES,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int CNT_W      = $clog2(IMAGE_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_rel,
    input  logic              cfg_clk,
    input  logic              cfg_data,
    input  logic              osc_clk,
    input  logic              usr_clk,
    input  logic              usr_clk_sel,
    output logic              src_oe,
    output logic              cfg_done,
    output logic              init_done,
    output logic              user_mode,
    output logic [CNT_W-1:0]  bit_count,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    in_lvls_t   raw, syn, prev;
    seq_state_e state, state_nx;
    logic       cfg_rise, osc_rise, usr_rise, init_tick;
    logic       stat_s, abort, clr;
    logic       full, fin;

    assign raw = '{stat: stat_rel, cfg_clk: cfg_clk, cfg_data: cfg_data,
                   osc: osc_clk, usr: usr_clk};

    cfg_in_sync #(.W(IN_LVLS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw),
        .dout (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= syn;
    end

    assign stat_s    = syn.stat;
    assign cfg_rise  = rising(prev.cfg_clk, syn.cfg_clk);
    assign osc_rise  = rising(prev.osc, syn.osc);
    assign usr_rise  = rising(prev.usr, syn.usr);
    assign init_tick = usr_clk_sel ? usr_rise : osc_rise;
    assign abort     = ~stat_s;
    assign clr       = rst | abort;

    cfg_bit_loader #(.IMAGE_BITS(IMAGE_BITS), .WORD_W(WORD_W)) u_loader (
        .clk      (clk),
        .clr      (clr),
        .en       (state == SEQ_LOAD),
        .tick     (cfg_rise),
        .din      (syn.cfg_data),
        .count    (bit_count),
        .full     (full),
        .word     (word_out),
        .word_stb (word_valid)
    );

    cfg_init_timer #(.INIT_CYCLES(INIT_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_timer (
        .clk     (clk),
        .clr     (clr),
        .tick    (init_tick),
        .done_in (cfg_done),
        .fin     (fin)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: if (stat_s) state_nx = SEQ_LOAD;
            SEQ_LOAD: if (full)   state_nx = SEQ_INIT;
            SEQ_INIT: if (fin)    state_nx = SEQ_USER;
            SEQ_USER: state_nx = SEQ_USER;
            default:  state_nx = SEQ_IDLE;
        endcase
        if (abort) state_nx = SEQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_IDLE;
        else     state <= state_nx;
    end

    assign src_oe    = (state == SEQ_LOAD);
    assign cfg_done  = (state == SEQ_INIT) || (state == SEQ_USER);
    assign init_done = (state == SEQ_USER);
    assign user_mode = init_done;
endmodule

// File: rtl/cfg_load_seq_chk.sv
module cfg_load_seq_chk #(
    parameter int IMAGE_BITS = 64,
    parameter int CNT_W      = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             stat_s,
    input logic             src_oe,
    input logic             cfg_done,
    input logic             init_done,
    input logic [CNT_W-1:0] bit_count
);
    AST_DONE_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> bit_count == CNT_W'(IMAGE_BITS)); // R4
    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_done && $past(cfg_done)) |-> $stable(bit_count)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        bit_count <= CNT_W'(IMAGE_BITS)); // R5
    AST_OE_OFF_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> !src_oe); // R5
    AST_INIT_AFTER_CFG: assert property (@(posedge clk) disable iff (rst)
        init_done |-> cfg_done); // R7
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !$past(stat_s) |-> (bit_count == '0 && !cfg_done && !init_done)); // R10
endmodule

bind cfg_load_seq cfg_load_seq_chk #(.IMAGE_BITS(IMAGE_BITS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stat_s    (stat_s),
    .src_oe    (src_oe),
    .cfg_done  (cfg_done),
    .init_done (init_done),
    .bit_count (bit_count)
);

// File: tb/tb_cfg_load_seq.sv
module tb_cfg_load_seq;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stat_rel = 1'b0, cfg_clk = 1'b0, cfg_data = 1'b0;
    logic osc_clk = 1'b0, usr_clk = 1'b0, usr_clk_sel = 1'b0;
    logic src_oe, cfg_done, init_done, user_mode, word_valid;
    logic [6:0] bit_count;
    logic [7:0] word_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cfg_load_seq dut (
        .clk(clk), .rst(rst), .stat_rel(stat_rel), .cfg_clk(cfg_clk),
        .cfg_data(cfg_data), .osc_clk(osc_clk), .usr_clk(usr_clk),
        .usr_clk_sel(usr_clk_sel), .src_oe(src_oe), .cfg_done(cfg_done),
        .init_done(init_done), .user_mode(user_mode), .bit_count(bit_count),
        .word_out(word_out), .word_valid(word_valid)
    );

    // image bytes and the word_out expected after each one
    localparam logic [7:0] IMG [NB] = '{8'hA5, 8'h3C, 8'hFF, 8'h00,
                                       8'h81, 8'h5A, 8'h0F, 8'hE7};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cfg(input logic b);
        cfg_data = b; cfg_clk = 1'b1; wclk(4);
        cfg_clk = 1'b0; wclk(4);
    endtask

    task automatic pulse_osc(input int n);
        for (int i = 0; i < n; i++) begin
            osc_clk = 1'b1; wclk(3); osc_clk = 1'b0; wclk(3);
        end
        wclk(2);
    endtask

    task automatic pulse_usr(input int n);
        for (int i = 0; i < n; i++) begin
            usr_clk = 1'b1; wclk(3); usr_clk = 1'b0; wclk(3);
        end
        wclk(2);
    endtask

    task automatic send_image();
        for (int k = 0; k < NB; k++)
            for (int b = 0; b < 8; b++) pulse_cfg(IMG[k][b]);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wclk(4);
        rst = 1'b0;
        wclk(2);
        // R1 reset state
        chk("R1 bit_count", int'(bit_count), 0);
        chk("R1 cfg_done", int'(cfg_done), 0);
        chk("R1 init_done", int'(init_done), 0);
        chk("R1 src_oe", int'(src_oe), 0);
        chk("R1 word_out", int'(word_out), 0);

        // R2 cfg edges before release ignored
        pulse_cfg(1'b1); pulse_cfg(1'b0);
        chk("R2 no load before release", int'(bit_count), 0);

        usr_clk_sel = 1'b1;
        stat_rel = 1'b1;
        wclk(6);
        chk("R2 src_oe on release", int'(src_oe), 1);

        // R9 user clock during loading has no effect
        pulse_usr(5);
        chk("R9 bit_count", int'(bit_count), 0);
        chk("R9 cfg_done", int'(cfg_done), 0);

        // table walk: R3 R4 R6
        for (int k = 0; k < NB; k++) begin
            for (int b = 0; b < 8; b++) pulse_cfg(IMG[k][b]);
            chk("R6 word_out", int'(word_out), int'(IMG[k]));
            chk("R3 bit_count", int'(bit_count), 8 * (k + 1));
            chk("R4 cfg_done", int'(cfg_done), (k == NB - 1) ? 1 : 0);
        end

        // R5 extra edges ignored
        pulse_cfg(1'b1); pulse_cfg(1'b0); pulse_cfg(1'b1);
        chk("R5 bit_count frozen", int'(bit_count), 64);
        chk("R5 src_oe off", int'(src_oe), 0);

        // R8 unselected oscillator, stalled user clock
        pulse_osc(400);
        chk("R8 stalled usr_clk", int'(init_done), 0);

        // R7 exact countdown on usr_clk
        pulse_usr(300);
        chk("R7 not yet at 300", int'(init_done), 0);
        pulse_usr(1);
        chk("R7 init_done at 301", int'(init_done), 1);
        chk("R11 user_mode", int'(user_mode), 1);

        // R10 abort from user mode
        stat_rel = 1'b0; wclk(6);
        chk("R10 bit_count", int'(bit_count), 0);
        chk("R10 cfg_done", int'(cfg_done), 0);
        chk("R10 init_done", int'(init_done), 0);
        chk("R11 user_mode", int'(user_mode), 0);

        // R10 abort mid-load
        stat_rel = 1'b1; wclk(6);
        for (int b = 0; b < 13; b++) pulse_cfg(1'b1);
        chk("R3 partial count", int'(bit_count), 13);
        stat_rel = 1'b0; wclk(6);
        chk("R10 mid-load clear", int'(bit_count), 0);

        // R10 abort mid-countdown, then default oscillator (R8)
        usr_clk_sel = 1'b0;
        stat_rel = 1'b1; wclk(6);
        send_image();
        pulse_osc(150);
        stat_rel = 1'b0; wclk(6);
        chk("R10 mid-init cfg_done", int'(cfg_done), 0);
        stat_rel = 1'b1; wclk(6);
        send_image();
        chk("R4 reload done", int'(cfg_done), 1);
        pulse_usr(400);
        chk("R8 usr ignored when osc selected", int'(init_done), 0);
        pulse_osc(300);
        chk("R7 osc not yet at 300", int'(init_done), 0);
        pulse_osc(1);
        chk("R7 osc init_done at 301", int'(init_done), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule